// File: doc/BRIEF.md
# Matrix-Vector Product Sum Engine

The engine evaluates the total of every entry of Y = A*B + C, where A is a square matrix of unsigned bytes, B a vector of unsigned bytes and C a vector of unsigned 16-bit words, and presents the low 24 bits of that total. The matrix side length is the parameter DIM (default 32; 128 in the target configuration). The operands sit in three behavioural memories inside the block. Each memory registers its read addresses on a clock edge and returns the data combinationally during the following cycle. A test environment preloads these memories before it issues a start pulse.

The walk is column-major. In each cycle a single B element, the one for the current column, is broadcast to 2*LANES multipliers. Lane k reads matrix rows k, k+LANES, k+2*LANES and so on through its own pair of read ports. During the first DIM/2 cycles the two ports of the C memory feed two C words into the same reduction. The products and the C words go into a binary adder tree with a register at every level. The tree output goes into a 24-bit accumulator. A done flag shows when the total is final.

Top module: `mvs_engine`

## Requirements
- R1: While reset is applied and in the cycle after it, result is 0 and done is 0.
- R2: When done is high, result equals (sum over r,c of A[r][c]*B[c] + sum over i of C[i]) mod 2^24, with all operands unsigned. The result changes only on cycles in which a reduced partial sum arrives.
- R3: Matrix element (r,c) is stored at memory word address r*DIM + c, and it is multiplied by B[c].
- R4: Every C element is counted exactly once, even when A is all zero.
- R5: No product or partial sum loses bits before the final 24-bit truncation. With every operand at its maximum, the result is the exact total reduced modulo 2^24.
- R6: With LEAVES the smallest power of two that is at least 2*LANES+2, done rises exactly DIM*DIM/(2*LANES) + log2(LEAVES) + 3 rising edges after the edge that samples start in the idle state. The default is 262 edges.
- R7: Result holds its final value during the cycle before done rises, and it stays stable while done is high.
- R8: Once high, done stays high until reset. A start pulse after completion changes neither result nor done.
- R9: A start pulse during the computation, in either the issue phase or the drain phase, is ignored. The latency and the result are unchanged.
- R10: A reset in the middle of a computation abandons it. A later start then produces the correct result with the R6 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins the computation when idle |
| result | output | 24 | Low 24 bits of the running, then final, total |
| done | output | 1 | High once the total is final; sticky until reset |

## Verification
Two pairs of events can land on the same edge. In the first, a new start pulse arrives while the issue counter or the drain pipeline is still active. In the second, the last partial sum is accumulated while the completion flag is about to be raised. The bench provokes the first by pulsing start partway through the issue phase and again two edges before completion. It judges the outcome by the exact completion latency and by the final total. For the second, the bench compares the value of result in the cycle just before done rises against the independently computed total. A further scenario places single nonzero matrix elements at the corners and at off-diagonal positions, so that any transposed or misaligned address stands out.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

    localparam int RES_W  = 24;
    localparam int A_W    = 8;
    localparam int B_W    = 8;
    localparam int C_W    = 16;
    localparam int PROD_W = A_W + B_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_FIN
    } state_e;

    // Smallest power of two holding 2*lanes products plus two C words.
    function automatic int leaf_count(input int lanes);
        int n;
        n = 1;
        while (n < 2 * lanes + 2) n = n * 2;
        return n;
    endfunction

endpackage

// File: rtl/mvs_opmem.sv
module mvs_opmem #(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int NP = 2
) (
    input  logic                   clk,
    input  logic [NP-1:0][AW-1:0]  addr,
    output logic [NP-1:0][DW-1:0]  data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]          cells [DEPTH];
    logic [NP-1:0][AW-1:0]  addr_q;

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '0;
    end

    always_ff @(posedge clk) addr_q <= addr;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign data[p] = cells[addr_q[p]];
    end
endmodule

// File: rtl/mvs_ctrl.sv
module mvs_ctrl
    import mvs_pkg::*;
#(
    parameter int DIM    = 32,
    parameter int LANES  = 2,
    parameter int PIPE_D = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    output logic                        issue,
    output logic                        cen_q,
    output logic                        root_vld,
    output logic                        done,
    output logic [$clog2(DIM*DIM/(2*LANES))-1:0] cnt,
    output logic [2*LANES-1:0][2*$clog2(DIM)-1:0] a_addr,
    output logic [0:0][$clog2(DIM)-1:0] b_addr,
    output logic [1:0][$clog2(DIM)-1:0] c_addr
);
    localparam int NPA   = 2 * LANES;
    localparam int GRPS  = DIM / NPA;
    localparam int TOTAL = DIM * GRPS;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int GRP_W = $clog2(GRPS);
    localparam int RW    = $clog2(DIM);
    localparam int AW    = 2 * RW;

    state_e            st;
    logic [PIPE_D-1:0] vpipe;
    int                col_i;
    int                grp_i;

    assign issue    = (st == ST_RUN);
    assign done     = (st == ST_FIN);
    assign root_vld = vpipe[PIPE_D-1];

    always_comb begin
        col_i = int'(cnt) >> GRP_W;
        grp_i = int'(cnt) & (GRPS - 1);
    end

    for (genvar p = 0; p < NPA; p++) begin : g_aaddr
        assign a_addr[p] = AW'((grp_i * NPA + p) * DIM + col_i);
    end
    assign b_addr[0] = RW'(col_i);
    assign c_addr[0] = RW'(2 * int'(cnt));
    assign c_addr[1] = RW'(2 * int'(cnt) + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            vpipe <= '0;
            cen_q <= 1'b0;
        end else begin
            vpipe <= {vpipe[PIPE_D-2:0], issue};
            cen_q <= issue && (int'(cnt) < DIM / 2);
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_RUN;
                    cnt <= '0;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(TOTAL - 1)) st <= ST_DRAIN;
                end
                ST_DRAIN: if (vpipe == '0) st <= ST_FIN;
                default: st <= ST_FIN;
            endcase
        end
    end
endmodule

// File: rtl/mvs_reduce.sv
module mvs_reduce #(
    parameter int LEAVES = 8,
    parameter int IN_W   = 16,
    parameter int OUT_W  = 19
) (
    input  logic                        clk,
    input  logic [LEAVES-1:0][IN_W-1:0] leaf_in,
    output logic [OUT_W-1:0]            root
);
    // Heap layout: node 1 is the root, leaves at LEAVES..2*LEAVES-1.
    logic [OUT_W-1:0] node [1:2*LEAVES-1];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LEAVES; i++)
            node[LEAVES+i] <= OUT_W'(leaf_in[i]);
        for (int n = 1; n < LEAVES; n++)
            node[n] <= node[2*n] + node[2*n+1];
    end

    assign root = node[1];
endmodule

// File: rtl/mvs_engine.sv
module mvs_engine
    import mvs_pkg::*;
#(
    parameter int DIM   = 32,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [23:0]      result,
    output logic             done
);
    localparam int NPA    = 2 * LANES;
    localparam int TOTAL  = DIM * DIM / NPA;
    localparam int CNT_W  = $clog2(TOTAL);
    localparam int RW     = $clog2(DIM);
    localparam int AW     = 2 * RW;
    localparam int LEAVES = leaf_count(LANES);
    localparam int LVLS   = $clog2(LEAVES);
    localparam int TREE_W = PROD_W + LVLS;
    localparam int PIPE_D = 2 + LVLS;

    logic                         issue;
    logic                         cen_q;
    logic                         root_vld;
    logic [CNT_W-1:0]             cnt;
    logic [NPA-1:0][AW-1:0]       a_addr;
    logic [0:0][RW-1:0]           b_addr;
    logic [1:0][RW-1:0]           c_addr;
    logic [NPA-1:0][A_W-1:0]      a_data;
    logic [0:0][B_W-1:0]          b_data;
    logic [1:0][C_W-1:0]          c_data;
    logic [LEAVES-1:0][PROD_W-1:0] leaf;
    logic [TREE_W-1:0]            root;
    logic [RES_W-1:0]             acc;

    mvs_ctrl #(.DIM(DIM), .LANES(LANES), .PIPE_D(PIPE_D)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .issue(issue), .cen_q(cen_q), .root_vld(root_vld), .done(done),
        .cnt(cnt), .a_addr(a_addr), .b_addr(b_addr), .c_addr(c_addr)
    );

    mvs_opmem #(.DW(A_W), .AW(AW), .NP(NPA)) u_mem_a (
        .clk(clk), .addr(a_addr), .data(a_data)
    );
    mvs_opmem #(.DW(B_W), .AW(RW), .NP(1)) u_mem_b (
        .clk(clk), .addr(b_addr), .data(b_data)
    );
    mvs_opmem #(.DW(C_W), .AW(RW), .NP(2)) u_mem_c (
        .clk(clk), .addr(c_addr), .data(c_data)
    );

    for (genvar p = 0; p < LEAVES; p++) begin : g_leaf
        if (p < NPA) begin : g_mul
            assign leaf[p] = PROD_W'(a_data[p]) * PROD_W'(b_data[0]);
        end else if (p < NPA + 2) begin : g_cword
            assign leaf[p] = cen_q ? PROD_W'(c_data[p-NPA]) : '0;
        end else begin : g_pad
            assign leaf[p] = '0;
        end
    end

    mvs_reduce #(.LEAVES(LEAVES), .IN_W(PROD_W), .OUT_W(TREE_W)) u_tree (
        .clk(clk), .leaf_in(leaf), .root(root)
    );

    always_ff @(posedge clk) begin
        if (rst)           acc <= '0;
        else if (root_vld) acc <= acc + RES_W'(root);
    end

    assign result = acc;
endmodule

// File: rtl/mvs_engine_chk.sv
module mvs_engine_chk #(
    parameter int CNT_W = 8,
    parameter int LAST  = 255
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [23:0]      result,
    input logic             issue,
    input logic             root_vld,
    input logic [CNT_W-1:0] cnt
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!done && result == 24'd0));

    assert_acc_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !root_vld |=> $stable(result));

    assert_result_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(result));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(root_vld, 2) && !$past(root_vld)));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (issue && start && cnt != CNT_W'(LAST)) |=> (issue && cnt == $past(cnt) + 1'b1));
endmodule

bind mvs_engine mvs_engine_chk #(.CNT_W(CNT_W), .LAST(TOTAL - 1)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .result(result),
    .issue(issue), .root_vld(root_vld), .cnt(cnt)
);

// File: tb/tb_mvs_engine.sv
module tb_mvs_engine;
    localparam int DIM    = 32;
    localparam int LANES  = 2;
    localparam int NA     = DIM * DIM;
    localparam int LEAVES = 8;   // smallest power of two >= 2*LANES+2
    localparam int LAT    = DIM * DIM / (2 * LANES) + $clog2(LEAVES) + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] result;
    logic        done;

    int ref_a [NA];
    int ref_b [DIM];
    int ref_c [DIM];
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mvs_engine #(.DIM(DIM), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .start(start), .result(result), .done(done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_sum();
        longint s = 0;
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++)
                s += longint'(ref_a[r*DIM+c]) * longint'(ref_b[c]);
        for (int i = 0; i < DIM; i++) s += longint'(ref_c[i]);
        return s[23:0];
    endfunction

    task automatic push_mem();
        for (int i = 0; i < NA; i++)  dut.u_mem_a.cells[i] = 8'(ref_a[i]);
        for (int i = 0; i < DIM; i++) dut.u_mem_b.cells[i] = 8'(ref_b[i]);
        for (int i = 0; i < DIM; i++) dut.u_mem_c.cells[i] = 16'(ref_c[i]);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs one computation; optional extra start pulses at edge counts inj1/inj2.
    task automatic run(input int inj1, input int inj2, output int lat, output logic [23:0] pre);
        int n = 0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        pre = result;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (n == inj1 || n == inj2);
            if (!done) pre = result;
        end while (!done && n < 4000);
        start = 1'b0;
        lat = n;
    endtask

    task automatic t_reset();
        do_reset();
        check(result == 24'd0, "R1 result after reset", result, 0);
        check(done == 1'b0, "R1 done after reset", done, 0);
    endtask

    task automatic t_random();
        int lat; logic [23:0] pre, e;
        for (int i = 0; i < NA; i++)  ref_a[i] = int'($urandom_range(0, 255));
        for (int i = 0; i < DIM; i++) ref_b[i] = int'($urandom_range(0, 255));
        for (int i = 0; i < DIM; i++) ref_c[i] = int'($urandom_range(0, 65535));
        push_mem(); do_reset();
        e = expect_sum();
        run(-1, -1, lat, pre);
        check(lat == LAT, "R6 latency random", lat, LAT);
        check(result == e, "R2 total random", result, e);
        check(pre == e, "R7 final before done", pre, e);
        repeat (5) @(negedge clk);
        check(done && result == e, "R7 stable while done", result, e);
    endtask

    task automatic t_max();
        int lat; logic [23:0] pre, e;
        for (int i = 0; i < NA; i++)  ref_a[i] = 255;
        for (int i = 0; i < DIM; i++) ref_b[i] = 255;
        for (int i = 0; i < DIM; i++) ref_c[i] = 65535;
        push_mem(); do_reset();
        e = expect_sum();
        run(-1, -1, lat, pre);
        check(result == e, "R5 max operands wrap", result, e);
    endtask

    task automatic t_conly();
        int lat; logic [23:0] pre, e;
        for (int i = 0; i < NA; i++)  ref_a[i] = 0;
        for (int i = 0; i < DIM; i++) ref_b[i] = int'($urandom_range(1, 255));
        for (int i = 0; i < DIM; i++) ref_c[i] = 1000 + i * 37;
        push_mem(); do_reset();
        e = expect_sum();
        run(-1, -1, lat, pre);
        check(result == e, "R4 C counted once", result, e);
    endtask

    task automatic t_single(input int r, input int c);
        int lat; logic [23:0] pre, e;
        for (int i = 0; i < NA; i++)  ref_a[i] = 0;
        for (int i = 0; i < DIM; i++) ref_b[i] = i + 1;
        for (int i = 0; i < DIM; i++) ref_c[i] = 0;
        ref_a[r*DIM+c] = 3;
        push_mem(); do_reset();
        e = expect_sum();
        run(-1, -1, lat, pre);
        check(result == e, $sformatf("R3 element (%0d,%0d)", r, c), result, e);
    endtask

    task automatic t_busy_start();
        int lat; logic [23:0] pre, e;
        for (int i = 0; i < NA; i++)  ref_a[i] = (i * 7) % 256;
        for (int i = 0; i < DIM; i++) ref_b[i] = (i * 13 + 5) % 256;
        for (int i = 0; i < DIM; i++) ref_c[i] = i * 511;
        push_mem(); do_reset();
        e = expect_sum();
        run(50, LAT - 2, lat, pre);
        check(lat == LAT, "R9 latency with busy start", lat, LAT);
        check(result == e, "R9 total with busy start", result, e);
    endtask

    task automatic t_after_done();
        logic [23:0] held;
        held = result;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (300) @(negedge clk);
        check(done == 1'b1, "R8 done sticky", done, 1);
        check(result == held, "R8 start after done ignored", result, held);
    endtask

    task automatic t_abort();
        int lat; logic [23:0] pre, e;
        e = expect_sum();
        do_reset();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        do_reset();
        check(result == 24'd0 && !done, "R10 abort clears", result, 0);
        run(-1, -1, lat, pre);
        check(lat == LAT, "R10 latency after abort", lat, LAT);
        check(result == e, "R10 total after abort", result, e);
    endtask

    initial begin
        #(200000 * 4);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_random();
        t_after_done();
        t_max();
        t_conly();
        t_single(0, 0);
        t_single(DIM - 1, DIM - 1);
        t_single(5, 17);
        t_single(17, 5);
        t_single(DIM - 1, 0);
        t_busy_start();
        t_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule